// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous static memory, 18 bits wide and split into two 9-bit bytes, with a parameterised depth. Reads are pipelined with a latency of two clock edges. Writes are delayed to match. The write command, address and byte enables are registered on one edge, and the write data is taken from the input bus two enabled edges later. Because both directions use the same two-edge offset, reads and writes can follow each other in any order with no idle bus cycles between them.

A command is loaded when the advance input is low. Three select inputs qualify the command. While advance is high, the block continues the burst that was started by the last load. It steps a 2-bit burst counter in either interleaved or linear order, and keeps the burst type (read, write or deselect) of that starting cycle. A hold input freezes every register of the block. The data path is presented as a separate input bus, an output bus and a drive-enable pin. The drive enable is gated asynchronously by an output-enable input.

Top module: `lw_sram`

## Requirements
- R1: With `adv` low and the block selected, `cmd_rd` high loads a read and `cmd_rd` low loads a write, at the given `addr`.
- R2: Read data for a read command appears on `dout` with `drv_en` high after the second enabled clock edge that follows the edge registering the command.
- R3: The block is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. A load while not selected is a deselect: it produces no bus drive two enabled edges later. Operations already in the pipeline still complete.
- R4: Write data is sampled on `din` at the second enabled edge after the edge registering the write command. A read issued on any later edge, including the very next one, returns the newly written data.
- R5: While `clk_hold` is high, no register changes and no write is performed. Bus drive stays on if a read result is on the bus, and stays off otherwise.
- R6: `byte_we_n[0]` (active low) enables writing of bits 8:0, and `byte_we_n[1]` enables writing of bits 17:9. A write with both bits high leaves the memory unchanged. During write data cycles the bus is never driven, whatever the level of `out_en_n`.
- R7: `out_en_n` high forces `drv_en` low at once, without waiting for a clock edge.
- R8: With `adv` high, the address, select and `cmd_rd` inputs are ignored. The next burst address replaces the two low address bits: with `burst_xor`=1 it is start XOR count, and with `burst_xor`=0 it is (start + count) mod 4. The address wraps to the start after the fourth beat.
- R9: A continue cycle that follows a deselect is also a deselect and leaves the bus undriven. After reset, a continue cycle behaves as a deselect.
- R10: After reset, `drv_en` is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_hold | input | 1 | High freezes the whole block for the cycle |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| cmd_rd | input | 1 | 1 = read, 0 = write (on load) |
| byte_we_n | input | 2 | Per-byte write enables, active low |
| burst_xor | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | AW | Word address |
| din | input | 18 | Write data, taken two enabled edges after the write command |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 18 | Read data |
| drv_en | output | 1 | High when `dout` should drive the bus |

## Verification
The bench builds the block with `AW`=6, which gives a 64-word array. At that size a fill pass initialises every word, and random addresses collide often. As a result, read-after-write at distances of one, two and three edges occurs many times, and bursts regularly wrap inside their four-word group. Hold cycles, deselects, aborted and partial byte writes, and both burst orders are mixed at random. Each of them is also placed deliberately next to a pending write or read.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW = 8,
  parameter int BYTE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_hold,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                adv,
  input  logic                cmd_rd,
  input  logic [1:0]          byte_we_n,
  input  logic                burst_xor,
  input  logic [AW-1:0]       addr,
  input  logic [2*BYTE_W-1:0] din,
  input  logic                out_en_n,
  output logic [2*BYTE_W-1:0] dout,
  output logic                drv_en
);
  localparam int DW = 2 * BYTE_W;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {K_IDLE, K_RD, K_WR} kind_t;

  logic [DW-1:0] mem [DEPTH];

  logic          sel;
  kind_t         b_kind, c_kind, s1_kind, s2_kind;
  logic [AW-1:0] b_base, c_addr, s1_addr, s2_addr;
  logic [1:0]    b_cnt, cnt_nx, low_nx, s1_bw, s2_bw;
  logic          out_vld;
  logic [DW-1:0] out_q;

  assign sel    = !sel_a_n && sel_b && !sel_c_n;
  assign cnt_nx = b_cnt + 2'd1;
  assign low_nx = burst_xor ? (b_base[1:0] ^ cnt_nx) : (b_base[1:0] + cnt_nx);

  always_comb begin
    if (!adv) begin
      c_kind = sel ? (cmd_rd ? K_RD : K_WR) : K_IDLE;
      c_addr = addr;
    end else begin
      c_kind = b_kind;
      c_addr = {b_base[AW-1:2], low_nx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_kind  <= K_IDLE;
      b_base  <= '0;
      b_cnt   <= '0;
      s1_kind <= K_IDLE;
      s1_addr <= '0;
      s1_bw   <= '1;
      s2_kind <= K_IDLE;
      s2_addr <= '0;
      s2_bw   <= '1;
      out_vld <= 1'b0;
    end else if (!clk_hold) begin
      if (!adv) begin
        b_kind <= c_kind;
        b_base <= addr;
        b_cnt  <= '0;
      end else begin
        b_cnt <= cnt_nx;
      end
      s1_kind <= c_kind;
      s1_addr <= c_addr;
      s1_bw   <= byte_we_n;
      s2_kind <= s1_kind;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      out_vld <= (s2_kind == K_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (!clk_hold) begin
      if (s2_kind == K_RD) out_q <= mem[s2_addr];
      if (s2_kind == K_WR)
        for (int b = 0; b < 2; b++)
          if (!s2_bw[b]) mem[s2_addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
    end
  end

  assign dout   = out_q;
  assign drv_en = out_vld && !out_en_n;

  assert_load_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !adv && sel && !cmd_rd) |=> (s1_kind == K_WR));

  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && !adv && !sel) |=> (s1_kind == K_IDLE));

  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |=> ($stable(out_vld) && $stable(s1_kind) && $stable(s2_kind) && $stable(b_cnt)));

  assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && s2_kind == K_WR) |=> !drv_en);

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !out_en_n);

  assert_cont_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_hold && adv && b_kind == K_IDLE) |=> (s1_kind == K_IDLE));
endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 0, rst_n = 0;
  logic clk_hold = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1, adv = 0, cmd_rd = 1;
  logic [1:0] byte_we_n = 2'b11;
  logic burst_xor = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic out_en_n = 0;
  logic [DW-1:0] dout;
  logic drv_en;

  lw_sram #(.AW(AW), .BYTE_W(9)) u_lw_sram (
    .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .cmd_rd(cmd_rd), .byte_we_n(byte_we_n),
    .burst_xor(burst_xor), .addr(addr), .din(din), .out_en_n(out_en_n),
    .dout(dout), .drv_en(drv_en));

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0, checking = 0;
  string cur_req = "R10";

  logic [DW-1:0] ref_mem [64];
  int q_k[$], q_a[$], q_b[$];
  int m_kind, m_base, m_cnt;
  bit exp_rd;
  logic [DW-1:0] exp_data;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: each enabled edge retires the operation issued two enabled edges earlier.
  always @(posedge clk) begin
    if (!rst_n) begin
      q_k = {0, 0}; q_a = {0, 0}; q_b = {3, 3};
      m_kind = 0; m_base = 0; m_cnt = 0; exp_rd = 0;
    end else if (!clk_hold) begin
      int ok, oa, ob, nk, na;
      ok = q_k.pop_front(); oa = q_a.pop_front(); ob = q_b.pop_front();
      exp_rd = (ok == 1);
      if (ok == 1) exp_data = ref_mem[oa];
      if (ok == 2) begin
        if (ob % 2 == 0) ref_mem[oa][8:0] = din[8:0];
        if (ob / 2 == 0) ref_mem[oa][17:9] = din[17:9];
      end
      if (!adv) begin
        nk = (!sel_a_n && sel_b && !sel_c_n) ? (cmd_rd ? 1 : 2) : 0;
        na = int'(addr);
        m_kind = nk; m_base = na; m_cnt = 0;
      end else begin
        int lo;
        m_cnt = (m_cnt + 1) % 4;
        lo = burst_xor ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        nk = m_kind;
        na = (m_base / 4) * 4 + lo;
      end
      q_k.push_back(nk); q_a.push_back(na); q_b.push_back(int'(byte_we_n));
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      check({cur_req, " drive"}, {17'd0, drv_en}, {17'd0, exp_rd && !out_en_n});
      if (exp_rd && !out_en_n) check({cur_req, " data"}, dout, exp_data);
    end
  end

  task automatic cyc(input bit hold, input bit ad, input bit rd, input bit s,
                     input int a, input logic [1:0] bw);
    @(negedge clk); #1;
    clk_hold = hold; adv = ad; cmd_rd = rd; addr = AW'(a); byte_we_n = bw;
    sel_a_n = !s; sel_b = s; sel_c_n = !s;
    din = DW'($urandom);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {17'd0, drv_en}, 18'd0);
    rst_n = 1;
    checking = 1;
    cur_req = "R10";
    cyc(0, 0, 1, 0, 0, 2'b11);
    cur_req = "R9";
    repeat (3) cyc(0, 1, 1, 1, 5, 2'b00);
    cur_req = "R4";
    for (int i = 0; i < 64; i++) cyc(0, 0, 0, 1, i, 2'b00);
    cur_req = "R2";
    for (int i = 0; i < 64; i++) cyc(0, 0, 1, 1, 63 - i, 2'b11);
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 1, 10 + i, 2'b00);
      cyc(0, 0, 1, 1, 10 + i, 2'b11);
      cyc(0, 0, 1, 1, 10 + i, 2'b11);
    end
    cur_req = "R6";
    cyc(0, 0, 0, 1, 20, 2'b10);
    cyc(0, 0, 0, 1, 21, 2'b01);
    cyc(0, 0, 0, 1, 22, 2'b11);
    cyc(0, 0, 1, 1, 20, 2'b11);
    cyc(0, 0, 1, 1, 21, 2'b11);
    cyc(0, 0, 1, 1, 22, 2'b11);
    repeat (3) cyc(0, 0, 1, 0, 0, 2'b11);
    cur_req = "R8";
    for (int m = 0; m < 2; m++) begin
      burst_xor = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 1, 1, 32 + s, 2'b11);
        repeat (5) cyc(0, 1, 0, 0, 7, 2'b00);
        cyc(0, 0, 0, 1, 40 + s, 2'b00);
        repeat (4) cyc(0, 1, 1, 0, 1, 2'b00);
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, 40 + k, 2'b11);
      end
    end
    cur_req = "R5";
    cyc(0, 0, 1, 1, 3, 2'b11);
    cyc(0, 0, 0, 1, 4, 2'b00);
    repeat (4) cyc(1, 0, 0, 1, 9, 2'b00);
    cyc(0, 0, 1, 1, 4, 2'b11);
    repeat (3) cyc(1, 0, 1, 1, 4, 2'b11);
    repeat (3) cyc(0, 0, 1, 0, 0, 2'b11);
    cur_req = "R3";
    cyc(0, 0, 1, 1, 6, 2'b11);
    cyc(0, 0, 1, 0, 6, 2'b11);
    cyc(0, 0, 0, 0, 6, 2'b00);
    cyc(0, 1, 0, 1, 6, 2'b00);
    cyc(0, 0, 1, 1, 6, 2'b11);
    cyc(0, 0, 1, 1, 6, 2'b11);
    cur_req = "R7";
    cyc(0, 0, 1, 1, 7, 2'b11);
    repeat (2) cyc(0, 0, 1, 0, 0, 2'b11);
    @(posedge clk); #2;
    out_en_n = 1; #1;
    check("R7", {17'd0, drv_en}, 18'd0);
    out_en_n = 0;
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) burst_xor = $urandom_range(0, 1);
      out_en_n = ($urandom_range(0, 9) == 0);
      cyc($urandom_range(0, 9) == 0, $urandom_range(0, 9) < 3, $urandom_range(0, 1),
          $urandom_range(0, 9) != 0, $urandom_range(0, 63), 2'($urandom));
    end
    out_en_n = 0;
    repeat (4) cyc(0, 0, 1, 0, 0, 2'b11);
    @(negedge clk);
    finish_run();
  end
endmodule